// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This unit is a registered datapath slice for a processor's execute stage. It handles the four bit-field operations on 32-bit words. Two of them write into a destination word: insert a field and clear a field. The other two read a field out of a source word: unsigned extract and signed extract.

The caller gives the operation, the destination word, the source word, the field's lowest bit position and the field's width in bits, and raises `start` for one cycle. The result appears one clock later, together with a one-cycle `done` strobe. Position and width are independent run-time controls. All four operations share one mask generator.

A request whose field does not fit inside the word is not wrapped. It raises `err` and returns zero. Instruction decode, register-file access and flag updates belong to the surrounding pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: With `op_i` = 0 (insert), the result holds the low `width_i` bits of `src_i` at bits [`lsb_i`+`width_i`-1 : `lsb_i`]. Every other bit equals `dst_i`.
- R2: With `op_i` = 1 (clear), bits [`lsb_i`+`width_i`-1 : `lsb_i`] of the result are zero. Every other bit equals `dst_i`.
- R3: With `op_i` = 2 (unsigned extract), the result is `src_i`[`lsb_i`+`width_i`-1 : `lsb_i`] moved down to bit 0, with zeros above the field.
- R4: With `op_i` = 3 (signed extract), the result is the same right-aligned field. Every bit above the field copies the field's most significant bit.
- R5: A request with `width_i` = 0 or `lsb_i`+`width_i` > 32 gives `err_o` = 1 and `result_o` = 0 in its `done_o` cycle. Legal requests give `err_o` = 0.
- R6: `done_o` is high in exactly the cycle after a cycle with `start` high, and low otherwise. `err_o` is never high without `done_o`.
- R7: `result_o` keeps its last value in every cycle that follows a cycle without `start`.
- R8: While reset is asserted and right after it, `done_o`, `err_o` and `result_o` are zero.
- R9: The full-word field (`lsb_i` = 0, `width_i` = 32) and the top-bit field (`lsb_i` = 31, `width_i` = 1) are legal. They give the results defined in R1–R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled on the clock edge |
| op_i | input | 2 | Operation: 0 insert, 1 clear, 2 unsigned extract, 3 signed extract |
| dst_i | input | 32 | Original destination word (insert, clear) |
| src_i | input | 32 | Source word (insert, extracts) |
| lsb_i | input | 5 | Lowest bit position of the field |
| width_i | input | 6 | Field width in bits, 1 to 32 |
| done_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | Request was illegal; the result is zero |
| result_o | output | 32 | Registered result |

## Verification
All four operations take their mask from one generator. A wrong mask therefore corrupts bits at the field edges, or bits that should have been preserved, in the very next `done_o` cycle. A fault at a field edge only shows for some position/width pairs. Random position and width values catch such faults, and directed requests at the word edges and at the legality boundary (`lsb_i`+`width_i` of exactly 32 and of 33) catch the rest.

A fault in the result register appears as a missing or doubled strobe, or as a result that drifts while the unit is idle. It shows within one cycle.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    typedef enum logic [1:0] {
        BF_INSERT = 2'd0,
        BF_CLEAR  = 2'd1,
        BF_UEXT   = 2'd2,
        BF_SEXT   = 2'd3
    } bf_op_e;
endpackage

// File: rtl/bfu_range_check.sv
module bfu_range_check #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int WID_W  = POS_W + 1
) (
    input  logic [POS_W-1:0] lsb_i,
    input  logic [WID_W-1:0] width_i,
    output logic             illegal_o
);
    localparam int SUM_W = WID_W + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DATA_W);

    logic [SUM_W-1:0] end_pos;

    always_comb begin
        end_pos   = SUM_W'(lsb_i) + SUM_W'(width_i);
        illegal_o = (width_i == '0) || (end_pos > LIMIT);
    end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int WID_W  = POS_W + 1
) (
    input  logic [POS_W-1:0]  lsb_i,
    input  logic [WID_W-1:0]  width_i,
    output logic [DATA_W-1:0] low_mask_o,
    output logic [DATA_W-1:0] field_mask_o,
    output logic [DATA_W-1:0] top_bit_o
);
    localparam int SUM_W = WID_W + 1;

    logic [SUM_W-1:0] lo_pos;
    logic [SUM_W-1:0] hi_pos;

    always_comb begin
        lo_pos = SUM_W'(lsb_i);
        hi_pos = SUM_W'(lsb_i) + SUM_W'(width_i);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
        always_comb begin
            low_mask_o[i]   = IDX < SUM_W'(width_i);
            field_mask_o[i] = (IDX >= lo_pos) && (IDX < hi_pos);
        end
    end

    always_comb begin
        top_bit_o = low_mask_o & ~(low_mask_o >> 1);
    end

    always_comb begin
        if (width_i <= WID_W'(DATA_W)) begin
            AST_MASK_SIZE: assert ($countones(low_mask_o) == int'(width_i)); // R9
        end
    end
endmodule

// File: rtl/bfu_field_core.sv
module bfu_field_core
    import bfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  bf_op_e            op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [POS_W-1:0]  lsb_i,
    input  logic [DATA_W-1:0] low_mask_i,
    input  logic [DATA_W-1:0] field_mask_i,
    input  logic [DATA_W-1:0] top_bit_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] unsigned_val;
    logic [DATA_W-1:0] fill;
    logic              sign_bit;

    always_comb begin
        placed       = src_i << lsb_i;
        aligned      = src_i >> lsb_i;
        unsigned_val = aligned & low_mask_i;
        sign_bit     = |(aligned & top_bit_i);
        fill         = sign_bit ? ~low_mask_i : '0;
        unique case (op_i)
            BF_INSERT: result_o = (dst_i & ~field_mask_i) | (placed & field_mask_i);
            BF_CLEAR:  result_o = dst_i & ~field_mask_i;
            BF_UEXT:   result_o = unsigned_val;
            BF_SEXT:   result_o = unsigned_val | fill;
            default:   result_o = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int WID_W  = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [POS_W-1:0]  lsb_i,
    input  logic [WID_W-1:0]  width_i,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic              done;
        logic              err;
        logic [DATA_W-1:0] result;
    } out_state_t;

    bf_op_e            op_sel;
    logic              illegal;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] raw_result;
    out_state_t        st_d;
    out_state_t        st_q;

    assign op_sel = bf_op_e'(op_i);

    bfu_range_check #(.DATA_W(DATA_W), .POS_W(POS_W), .WID_W(WID_W)) u_range (
        .lsb_i     (lsb_i),
        .width_i   (width_i),
        .illegal_o (illegal)
    );

    bfu_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .WID_W(WID_W)) u_mask (
        .lsb_i        (lsb_i),
        .width_i      (width_i),
        .low_mask_o   (low_mask),
        .field_mask_o (field_mask),
        .top_bit_o    (top_bit)
    );

    bfu_field_core #(.DATA_W(DATA_W), .POS_W(POS_W)) u_core (
        .op_i         (op_sel),
        .dst_i        (dst_i),
        .src_i        (src_i),
        .lsb_i        (lsb_i),
        .low_mask_i   (low_mask),
        .field_mask_i (field_mask),
        .top_bit_i    (top_bit),
        .result_o     (raw_result)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        st_d.err  = start && illegal;
        if (start) begin
            st_d.result = illegal ? '0 : raw_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign err_o    = st_q.err;
    assign result_o = st_q.result;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done_o); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R6
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (result_o == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result_o) && !done_o)); // R7
    AST_INSERT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !illegal && op_sel == BF_INSERT) |=>
            (((result_o ^ $past(dst_i)) & ~$past(field_mask)) == '0)); // R1
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !illegal && op_sel == BF_CLEAR) |=>
            ((result_o & $past(field_mask)) == '0)); // R2
    AST_UEXT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !illegal && op_sel == BF_UEXT) |=>
            ((result_o & ~$past(low_mask)) == '0)); // R3
endmodule

// File: tb/tb_bitfield_unit.sv
module tb_bitfield_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op_i;
    logic [31:0] dst_i;
    logic [31:0] src_i;
    logic [4:0]  lsb_i;
    logic [5:0]  width_i;
    logic        done_o;
    logic        err_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitfield_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i),
        .dst_i(dst_i), .src_i(src_i), .lsb_i(lsb_i), .width_i(width_i),
        .done_o(done_o), .err_o(err_o), .result_o(result_o)
    );

    function automatic bit ref_illegal(int l, int w);
        return (w == 0) || (l + w > 32);
    endfunction

    function automatic logic [31:0] ref_result(int op, logic [31:0] d, logic [31:0] s, int l, int w);
        logic [31:0] r;
        if (ref_illegal(l, w)) return 32'h0;
        for (int i = 0; i < 32; i++) begin
            bit in_f = (i >= l) && (i < l + w);
            case (op)
                0: r[i] = in_f ? s[i-l] : d[i];
                1: r[i] = in_f ? 1'b0 : d[i];
                2: r[i] = (i < w) ? s[i+l] : 1'b0;
                default: r[i] = (i < w) ? s[i+l] : s[l+w-1];
            endcase
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string op_req(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_op(int op, logic [31:0] d, logic [31:0] s, int l, int w, string tag);
        logic [31:0] exp = ref_result(op, d, s, l, w);
        bit bad = ref_illegal(l, w);
        @(negedge clk);
        start = 1'b1; op_i = 2'(op); dst_i = d; src_i = s;
        lsb_i = 5'(l); width_i = 6'(w);
        @(negedge clk);
        start = 1'b0;
        dst_i = ~d; src_i = ~s;
        check({tag, " done R6"}, 32'(done_o), 32'd1);
        check({tag, " err R5"}, 32'(err_o), 32'(bad));
        check(bad ? {tag, " R5"} : tag, result_o, exp);
        @(negedge clk);
        check("R6 done low when idle", 32'(done_o), 32'd0);
        check("R7 result held", result_o, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; op_i = '0; dst_i = '0; src_i = '0;
        lsb_i = '0; width_i = 6'd1;
        repeat (3) @(negedge clk);
        check("R8 reset done", 32'(done_o), 32'd0);
        check("R8 reset err", 32'(err_o), 32'd0);
        check("R8 reset result", result_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset done", 32'(done_o), 32'd0);

        // Directed corners
        run_op(0, 32'hFFFF_0000, 32'h0000_00AB, 8, 8, "R1 insert mid");
        run_op(1, 32'hFFFF_FFFF, 32'h0, 4, 12, "R2 clear mid");
        run_op(2, 32'h0, 32'hDEAD_BEEF, 16, 16, "R3 uext high half");
        run_op(3, 32'h0, 32'h0000_0F00, 8, 4, "R4 sext negative");
        run_op(3, 32'h0, 32'h0000_0700, 8, 4, "R4 sext positive");
        for (int op = 0; op < 4; op++) begin
            run_op(op, 32'h1234_5678, 32'h8765_4321, 0, 32, "R9 full word");
            run_op(op, 32'h7FFF_FFFF, 32'h8000_0000, 31, 1, "R9 top bit");
            run_op(op, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 30, 2, "R9 edge fit");
            run_op(op, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 31, 2, "R5 overflow");
            run_op(op, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 3, 0, "R5 zero width");
        end

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom_range(3, 0));
            int l  = int'($urandom_range(31, 0));
            int w  = ($urandom_range(9, 0) == 0) ? int'($urandom_range(32, 0))
                                                 : int'($urandom_range(32 - l, 1));
            run_op(op, $urandom, $urandom, l, w,
                   ref_illegal(l, w) ? "R5 random" : op_req(op));
        end

        // Back-to-back starts keep done high
        @(negedge clk);
        start = 1'b1; op_i = 2'd2; src_i = 32'hF0; lsb_i = 5'd4; width_i = 6'd4;
        @(negedge clk);
        src_i = 32'hA00; lsb_i = 5'd8;
        check("R6 first of pair", 32'(done_o), 32'd1);
        check("R3 first of pair", result_o, 32'hF);
        @(negedge clk);
        start = 1'b0;
        check("R6 second of pair", 32'(done_o), 32'd1);
        check("R3 second of pair", result_o, 32'hA);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule